// File: doc/BRIEF.md
# Fieldbus Transmit Header Parser and Packet Sequencer

This block sits between a host byte stream, which arrives from a UART receiver, and a byte-level Manchester encoder on a half-duplex fieldbus segment. The host arms each transmission with a four-byte header. The header selects the output polarity and sets three things: a FIFO low-water alarm level, the number of preamble bytes and a jabber timeout. The block keeps the jabber timeout for a separate jabber timer. Once the block is armed, every further host byte is stored in a transmit FIFO.

Transmission starts when three conditions hold: the block is armed, the FIFO holds at least one byte, and the receive path reports no reception in progress. The sequencer then hands the encoder the preamble bytes, a start delimiter, the FIFO contents and an end delimiter. The end delimiter goes out on its own as soon as the FIFO runs dry. Sending the end delimiter closes the packet and disarms the block, so the next packet needs a fresh header.

While a packet is being sent, an RTS-style alarm tells the host that the FIFO is running low, so that the host can keep feeding it at the encoder's rate of one byte per 256 µs.

Top module: `fbus_tx_seq`

## Requirements
- R1: A non-inverted header is accepted and arms the block. Its four bytes, in order, are 0xEA, a byte whose bits 7:5 are 100, a jabber byte, and 0xAE. The jabber byte then appears on `jab_timeout` and `enc_inv` is 0.
- R2: An inverted header is accepted and arms the block with `enc_inv` = 1. Its four bytes, in order, are 0x15, a byte whose bits 7:5 are 011, the jabber byte, and 0x51.
- R3: While the block is not armed, a header byte that does not fit its position is discarded and the parser returns to waiting for a first byte. No field changes and nothing is transmitted.
- R4: In the second header byte, bits 2:0 give the preamble count minus one. A packet is sent as that many preamble bytes (kind 0, value 0x55), one start delimiter (kind 1, 0xC5), the FIFO bytes in arrival order (kind 2), and one end delimiter (kind 3, 0xFD).
- R5: No transmission starts while `rx_busy` is high, or while the FIFO is empty, or while the block is unarmed.
- R6: When the FIFO is found empty during the data phase, the end delimiter is sent and the block disarms. Bytes that arrive after that are parsed as header bytes and start nothing by themselves.
- R7: `rts_alarm` is high whenever the FIFO level is at or below a threshold. Bits 4:3 of the second header byte select the threshold: codes 00, 01, 10 and 11 give 2, 4, 6 and 8 bytes. The threshold is 2 after reset.
- R8: A byte written to a full FIFO (DEPTH entries, default 16) is dropped and sets `overflow`, which stays high until reset.
- R9: While `enc_valid` is high and `enc_ready` is low, `enc_valid`, `enc_data` and `enc_kind` hold their values.
- R10: Bytes that arrive while the block is armed are queued and are not parsed as a header. A byte written in the same cycle as the last queued byte is taken by the encoder continues the packet as data.
- R11: After reset: `enc_valid` = 0, `overflow` = 0, `jab_timeout` = 0, `enc_inv` = 0 and `rts_alarm` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host byte strobe, one byte per cycle |
| in_data | input | 8 | Host byte |
| rx_busy | input | 1 | Receive path is busy; blocks the start of a packet |
| enc_valid | output | 1 | Byte offered to the encoder |
| enc_data | output | 8 | Byte value |
| enc_kind | output | 2 | 0 preamble, 1 start delimiter, 2 data, 3 end delimiter |
| enc_inv | output | 1 | Encoder should use inverted Manchester polarity |
| enc_ready | input | 1 | Encoder takes the byte on this edge |
| rts_alarm | output | 1 | FIFO level at or below the selected threshold |
| jab_timeout | output | 8 | Latched jabber timeout for the jabber timer |
| overflow | output | 1 | Sticky FIFO overflow flag |

## Verification
A host write into the FIFO and the encoder popping the last queued byte can happen on the same clock edge. On that edge the packet must either continue with the new byte or close. The bench provokes this by watching for the final data byte on the encoder port. It asserts `in_valid` in the same window as `enc_ready`, so that the push and the pop share one edge. It then expects the new byte to follow as data, with exactly one end delimiter after it. A second pairing is also tried: an overflowing write against a full FIFO. The bench judges it by the drained payload, which must lack the dropped byte, and by `overflow` staying high.

// File: rtl/fbus_tx_seq.sv
module fbus_tx_seq #(
  parameter int          DEPTH    = 16,
  parameter logic [7:0]  PRE_BYTE = 8'h55,
  parameter logic [7:0]  SOF_BYTE = 8'hC5,
  parameter logic [7:0]  EOF_BYTE = 8'hFD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       rx_busy,
  output logic       enc_valid,
  output logic [7:0] enc_data,
  output logic [1:0] enc_kind,
  output logic       enc_inv,
  input  logic       enc_ready,
  output logic       rts_alarm,
  output logic [7:0] jab_timeout,
  output logic       overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] K_PRE = 2'd0, K_SOF = 2'd1, K_DAT = 2'd2, K_EOF = 2'd3;

  typedef enum logic [2:0] {SQ_IDLE, SQ_PRE, SQ_SOF, SQ_DAT, SQ_EOF} sq_t;

  sq_t         sq;
  logic [1:0]  hp;
  logic        armed;
  logic        t_inv, inv_r;
  logic [1:0]  t_lvl, lvl_r;
  logic [2:0]  t_pre, pre_r, pre_left;
  logic [7:0]  t_jab, jab_r;
  logic [7:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire fire   = enc_valid && enc_ready;
  wire full   = (count == CW'(DEPTH));
  wire empty  = (count == '0);
  wire hb     = in_valid && !armed;
  wire push   = in_valid && armed && !full;
  wire pop    = (sq == SQ_DAT) && fire;
  wire h1_ok  = in_data[7:5] == (t_inv ? 3'b011 : 3'b100);
  wire h3_ok  = in_data == (t_inv ? 8'h51 : 8'hAE);
  wire [3:0] thr = {1'b0, lvl_r, 1'b0} + 4'd2;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // header parser
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hp    <= 2'd0;
      armed <= 1'b0;
      t_inv <= 1'b0;
      t_lvl <= 2'd0;
      t_pre <= 3'd0;
      t_jab <= 8'd0;
      inv_r <= 1'b0;
      lvl_r <= 2'd0;
      pre_r <= 3'd0;
      jab_r <= 8'd0;
    end else begin
      if (sq == SQ_EOF && fire) armed <= 1'b0;
      if (hb) begin
        case (hp)
          2'd0: if (in_data == 8'hEA || in_data == 8'h15) begin
                  t_inv <= (in_data == 8'h15);
                  hp    <= 2'd1;
                end
          2'd1: if (h1_ok) begin
                  t_lvl <= in_data[4:3];
                  t_pre <= in_data[2:0];
                  hp    <= 2'd2;
                end else begin
                  hp <= 2'd0;
                end
          2'd2: begin
                  t_jab <= in_data;
                  hp    <= 2'd3;
                end
          default: begin
                  hp <= 2'd0;
                  if (h3_ok) begin
                    armed <= 1'b1;
                    inv_r <= t_inv;
                    lvl_r <= t_lvl;
                    pre_r <= t_pre;
                    jab_r <= t_jab;
                  end
                end
        endcase
      end
    end
  end

  // transmit FIFO
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (in_valid && armed && full) overflow <= 1'b1;
    end
  end

  // packet sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq       <= SQ_IDLE;
      pre_left <= 3'd0;
    end else begin
      case (sq)
        SQ_IDLE: if (armed && !empty && !rx_busy) begin
                   sq       <= SQ_PRE;
                   pre_left <= pre_r;
                 end
        SQ_PRE:  if (fire) begin
                   if (pre_left == 3'd0) sq <= SQ_SOF;
                   else pre_left <= pre_left - 1'b1;
                 end
        SQ_SOF:  if (fire) sq <= SQ_DAT;
        SQ_DAT:  if (empty) sq <= SQ_EOF;
        SQ_EOF:  if (fire) sq <= SQ_IDLE;
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    enc_valid = 1'b1;
    enc_data  = PRE_BYTE;
    enc_kind  = K_PRE;
    case (sq)
      SQ_PRE: ;
      SQ_SOF: begin enc_data = SOF_BYTE;    enc_kind = K_SOF; end
      SQ_DAT: begin enc_data = mem[rd_ptr]; enc_kind = K_DAT; enc_valid = !empty; end
      SQ_EOF: begin enc_data = EOF_BYTE;    enc_kind = K_EOF; end
      default: enc_valid = 1'b0;
    endcase
  end

  assign enc_inv     = inv_r;
  assign jab_timeout = jab_r;
  assign rts_alarm   = (32'(count) <= 32'(thr));
endmodule

module fbus_tx_seq_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_busy,
  input logic          enc_valid,
  input logic          enc_ready,
  input logic [7:0]    enc_data,
  input logic [1:0]    enc_kind,
  input logic          overflow,
  input logic          armed,
  input logic [CW-1:0] count
);
  p_fifo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && !enc_ready |=> enc_valid && $stable(enc_data) && $stable(enc_kind));

  p_sof_to_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && enc_ready && enc_kind == 2'd1 |=> enc_kind == 2'd2);

  p_eof_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && enc_ready && enc_kind == 2'd3 |=> !enc_valid && !armed);

  p_start_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enc_valid) && enc_kind == 2'd0 |-> $past(!rx_busy) && $past(armed));
endmodule

bind fbus_tx_seq fbus_tx_seq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_busy(rx_busy), .enc_valid(enc_valid),
  .enc_ready(enc_ready), .enc_data(enc_data), .enc_kind(enc_kind),
  .overflow(overflow), .armed(armed), .count(count)
);

// File: tb/tb_fbus_tx_seq.sv
module tb_fbus_tx_seq;
  localparam int CLK_P = 10;
  localparam int Q = CLK_P / 4;
  localparam logic [7:0] PRE = 8'h55, SOF = 8'hC5, EOF = 8'hFD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, rx_busy = 1'b0, enc_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic enc_valid, enc_inv, rts_alarm, overflow;
  logic [7:0] enc_data, jab_timeout;
  logic [1:0] enc_kind;

  int n_tests = 0, n_fail = 0, cyc = 0, n_log = 0;
  logic [7:0] lg_d [64];
  logic [1:0] lg_k [64];
  logic       lg_i [64];
  bit done = 1'b0;

  fbus_tx_seq dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .rx_busy(rx_busy),
    .enc_valid(enc_valid), .enc_data(enc_data), .enc_kind(enc_kind), .enc_inv(enc_inv),
    .enc_ready(enc_ready), .rts_alarm(rts_alarm), .jab_timeout(jab_timeout), .overflow(overflow)
  );

  always #(CLK_P/2) clk = ~clk;

  always begin
    @(negedge clk);
    #Q;
    if (rst_n && enc_valid && enc_ready && n_log < 64) begin
      lg_d[n_log] = enc_data;
      lg_k[n_log] = enc_kind;
      lg_i[n_log] = enc_inv;
      n_log++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic hdr(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    send(b0); send(b1); send(b2); send(b3);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic entry(string req, int i, logic [1:0] k, logic [7:0] d, logic inv);
    chk(req, $sformatf("entry %0d kind", i), lg_k[i], k);
    chk(req, $sformatf("entry %0d data", i), lg_d[i], d);
    chk(req, $sformatf("entry %0d inv", i), lg_i[i], inv);
  endtask

  task automatic t_reset;
    #Q;
    chk("R11", "enc_valid", enc_valid, 0);
    chk("R11", "overflow", overflow, 0);
    chk("R11", "jab_timeout", jab_timeout, 0);
    chk("R11", "enc_inv", enc_inv, 0);
    chk("R11", "rts_alarm", rts_alarm, 1);
  endtask

  task automatic t_normal;
    rx_busy = 1'b1; enc_ready = 1'b1; n_log = 0;
    hdr(8'hEA, 8'h8A, 8'h33, 8'hAE);
    chk("R1", "jab_timeout", jab_timeout, 8'h33);
    chk("R1", "enc_inv", enc_inv, 0);
    send(8'hA1); send(8'hA2); send(8'hA3);
    idle(10);
    #Q chk("R5", "no start while busy", enc_valid, 0);
    chk("R5", "log empty while busy", n_log, 0);
    @(negedge clk) rx_busy = 1'b0;
    idle(30);
    chk("R4", "entry count", n_log, 8);
    for (int i = 0; i < 3; i++) entry("R4", i, 2'd0, PRE, 1'b0);
    entry("R4", 3, 2'd1, SOF, 1'b0);
    entry("R4", 4, 2'd2, 8'hA1, 1'b0);
    entry("R4", 5, 2'd2, 8'hA2, 1'b0);
    entry("R4", 6, 2'd2, 8'hA3, 1'b0);
    entry("R6", 7, 2'd3, EOF, 1'b0);
    send(8'h01);
    idle(10);
    chk("R6", "no packet without header", n_log, 8);
  endtask

  task automatic t_inverted;
    enc_ready = 1'b1; rx_busy = 1'b0; n_log = 0;
    hdr(8'h15, 8'h70, 8'h05, 8'h51);
    chk("R2", "jab_timeout", jab_timeout, 8'h05);
    chk("R2", "enc_inv", enc_inv, 1);
    send(8'hB7);
    idle(20);
    chk("R2", "entry count", n_log, 4);
    entry("R2", 0, 2'd0, PRE, 1'b1);
    entry("R2", 1, 2'd1, SOF, 1'b1);
    entry("R2", 2, 2'd2, 8'hB7, 1'b1);
    entry("R2", 3, 2'd3, EOF, 1'b1);
  endtask

  task automatic t_bad_header;
    enc_ready = 1'b1; rx_busy = 1'b0; n_log = 0;
    hdr(8'hEA, 8'hA0, 8'h77, 8'hAE);
    send(8'h42);
    hdr(8'h15, 8'h90, 8'h66, 8'h51);
    send(8'h43);
    hdr(8'hEA, 8'h80, 8'h22, 8'hAF);
    send(8'h44);
    idle(20);
    chk("R3", "nothing sent", n_log, 0);
    chk("R3", "jab unchanged", jab_timeout, 8'h05);
    chk("R3", "inv unchanged", enc_inv, 1);
    hdr(8'hEA, 8'h80, 8'h00, 8'hAE);
    send(8'h11);
    idle(20);
    chk("R3", "recovered entry count", n_log, 4);
    entry("R3", 2, 2'd2, 8'h11, 1'b0);
  endtask

  task automatic t_alarm;
    enc_ready = 1'b1; rx_busy = 1'b1; n_log = 0;
    hdr(8'hEA, 8'h98, 8'h00, 8'hAE);
    for (int i = 0; i < 8; i++) send(8'h20 + 8'(i));
    #Q chk("R7", "level 8 at code 11", rts_alarm, 1);
    send(8'h28);
    #Q chk("R7", "level 9 at code 11", rts_alarm, 0);
    @(negedge clk) rx_busy = 1'b0;
    idle(30);
    chk("R7", "drained entry count", n_log, 12);
    #Q chk("R7", "alarm after drain", rts_alarm, 1);
  endtask

  task automatic t_stall;
    logic [7:0] d0;
    logic [1:0] k0;
    enc_ready = 1'b0; rx_busy = 1'b0; n_log = 0;
    hdr(8'hEA, 8'h80, 8'h00, 8'hAE);
    send(8'hC3);
    idle(2);
    #Q;
    chk("R9", "valid raised", enc_valid, 1);
    d0 = enc_data; k0 = enc_kind;
    idle(4);
    #Q;
    chk("R9", "valid held", enc_valid, 1);
    chk("R9", "data held", enc_data, d0);
    chk("R9", "kind held", enc_kind, k0);
    @(negedge clk) enc_ready = 1'b1;
    idle(10);
    chk("R9", "entry count", n_log, 4);
    entry("R9", 2, 2'd2, 8'hC3, 1'b0);
  endtask

  task automatic t_collide;
    int guard;
    enc_ready = 1'b1; rx_busy = 1'b1; n_log = 0;
    hdr(8'hEA, 8'h80, 8'h00, 8'hAE);
    send(8'hD1);
    @(negedge clk) rx_busy = 1'b0;
    guard = 0;
    forever begin
      @(negedge clk);
      #Q;
      guard++;
      if ((enc_valid && enc_kind == 2'd2) || guard > 50) break;
    end
    in_valid = 1'b1; in_data = 8'hEA;
    @(negedge clk) in_valid = 1'b0;
    idle(15);
    chk("R10", "entry count", n_log, 5);
    entry("R10", 2, 2'd2, 8'hD1, 1'b0);
    entry("R10", 3, 2'd2, 8'hEA, 1'b0);
    entry("R10", 4, 2'd3, EOF, 1'b0);
  endtask

  task automatic t_overflow;
    enc_ready = 1'b1; rx_busy = 1'b1; n_log = 0;
    hdr(8'hEA, 8'h80, 8'h00, 8'hAE);
    send(8'h00); send(8'h01);
    #Q chk("R7", "level 2 at code 00", rts_alarm, 1);
    send(8'h02);
    #Q chk("R7", "level 3 at code 00", rts_alarm, 0);
    for (int i = 3; i < 16; i++) send(8'(i));
    #Q chk("R8", "no overflow at full", overflow, 0);
    send(8'hFF);
    #Q chk("R8", "overflow set", overflow, 1);
    @(negedge clk) rx_busy = 1'b0;
    idle(40);
    chk("R8", "entry count", n_log, 19);
    entry("R8", 17, 2'd2, 8'h0F, 1'b0);
    entry("R8", 18, 2'd3, EOF, 1'b0);
    chk("R8", "overflow sticky", overflow, 1);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    t_normal();
    t_inverted();
    t_bad_header();
    t_alarm();
    t_stall();
    t_collide();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule